// File: doc/BRIEF.md
# Serially Tuned Sine Synthesizer

This block is a numerically controlled oscillator. It produces one signed sine sample on every system clock, and an external D/A converter turns those samples into an analog tone. The output frequency equals word × Fclk / 2^32. For example, a 150 MHz clock with the word 0x0BF258BF gives about 7 MHz. A host loads a new 32-bit word serially over three lines: a frame line, a bit clock and a data line. The word is held in a staging register until a separate update strobe makes it the live word. This double buffering lets the frequency change in a single clean step while the oscillator keeps running.

The serial loader is a four-state machine. The states are:
- `LD_IDLE`: waiting for a frame.
- `LD_SHIFT`: collecting bits.
- `LD_FULL`: exactly 32 bits have been taken.
- `LD_OVER`: more than 32 bits have arrived.

The transitions are:
- *open*: `LD_IDLE` to `LD_SHIFT` when the frame goes high.
- *fill*: `LD_SHIFT` to `LD_FULL` on the 32nd bit-clock rise.
- *spill*: `LD_FULL` to `LD_OVER` on one more rise.
- *close*: any busy state to `LD_IDLE` when the frame drops. Only a close from `LD_FULL` commits the word.

Behind the loader, a 32-bit phase accumulator drives a two-stage quarter-wave sine lookup.

Top module: `nco_serial_synth`

## Requirements
- R1: Serial bits enter most significant bit first, one per rising edge of `ser_clk` seen while `ser_frame` is high. When the frame falls after exactly 32 bits, the received word becomes the staged word.
- R2: A frame that closes after fewer or more than 32 bits is discarded, and the staged word keeps its previous value.
- R3: A cycle with `upd` high copies the staged word into the live tuning word. Without `upd`, the live word and the output frequency do not change, even when a new frame is committed.
- R4: If `upd` is high in the same cycle that a frame closes with 32 bits, the live word takes the newly received word.
- R5: On every clock the phase advances by the live tuning word, modulo 2^32, with no saturation.
- R6: The output is a signed 16-bit sample defined from phase bits [31:22], as follows:
  - q = phase[31:30] and i = phase[29:22].
  - j = ~i when q[0] is 1, otherwise j = i.
  - v = round(32767·sin(2π(j+0.5)/1024)).
  - The sample is −v when q[1] is 1, otherwise +v.
- R7: The sample shown after a clock edge is computed from the phase value held two edges earlier.
- R8: A live tuning word of zero holds the output at one constant value.
- R9: While `rst` is high, the phase, the staged word and the live word are cleared and the output is 0.
- R10: Rising edges of `ser_clk` while `ser_frame` is low shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_frame | input | 1 | High for the duration of a serial word |
| ser_clk | input | 1 | Serial bit clock; its rise takes one bit (sampled on `clk`) |
| ser_dat | input | 1 | Serial data bit |
| upd | input | 1 | Update strobe: staged word becomes the live tuning word |
| sample_o | output | 16 | Signed sine sample toward the D/A converter |

## Verification
The two functions that can fall in one cycle are the frame close that commits a word and the update strobe that reads the staged word. The bench drops `ser_frame` and raises `upd` on the same falling clock edge. It then judges the result by comparing the following samples with a reference that advances its phase by the new word. A reference using the old word would diverge within a few samples.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_FULL  = 2'd2,
        LD_OVER  = 2'd3
    } ld_state_t;
endpackage

// File: rtl/nco_serial_loader.sv
module nco_serial_loader
    import nco_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_frame,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [WORD_W-1:0] stage_o,
    output logic              commit_o,
    output logic [WORD_W-1:0] commit_word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    ld_state_t         state_q, state_d;
    logic              sclk_d;
    logic              bit_edge;
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] stage_q;
    logic [CNT_W-1:0]  cnt_q;

    assign bit_edge = ser_clk & ~sclk_d & ser_frame;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= ser_clk;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LD_IDLE;
        else     state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (ser_frame) state_d = LD_SHIFT;
            LD_SHIFT: begin
                if (!ser_frame) state_d = LD_IDLE;
                else if (bit_edge && cnt_q == CNT_W'(WORD_W - 1)) state_d = LD_FULL;
            end
            LD_FULL: begin
                if (!ser_frame)    state_d = LD_IDLE;
                else if (bit_edge) state_d = LD_OVER;
            end
            LD_OVER:  if (!ser_frame) state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    assign commit_o      = (state_q == LD_FULL) && !ser_frame;
    assign commit_word_o = shreg_q;
    assign stage_o       = stage_q;

    // data path driven by the state
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            stage_q <= '0;
        end else begin
            if (state_q == LD_IDLE) cnt_q <= '0;
            if (bit_edge && (state_q == LD_SHIFT || state_q == LD_FULL)) begin
                shreg_q <= {shreg_q[WORD_W-2:0], ser_dat};
                if (state_q == LD_SHIFT) cnt_q <= cnt_q + 1'b1;
            end
            if (commit_o) stage_q <= shreg_q;
        end
    end

    // R2
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != LD_FULL) |=> $stable(stage_q));

    // R10
    idle_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!ser_frame && state_q == LD_IDLE) |=> $stable(shreg_q));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] phase_o
);
    logic [ACC_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + step_i;
    end

    assign phase_o = phase_q;

    // R5
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_q == ACC_W'($past(phase_q) + $past(step_i)));

    // R8
    zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i == '0) |=> $stable(phase_q));
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic signed [OUT_W-1:0] sample_o
);
    localparam int    IDX_W = ADDR_W - 2;
    localparam int    DEPTH = 1 << IDX_W;
    localparam int    FULL  = 1 << ADDR_W;
    localparam real   AMP   = real'((1 << (OUT_W - 1)) - 1);
    localparam real   TWO_PI = 6.283185307179586;

    logic [OUT_W-2:0] rom [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        localparam real ANG = TWO_PI * (real'(k) + 0.5) / real'(FULL);
        localparam int  MAG = $rtoi(AMP * $sin(ANG) + 0.5);
        assign rom[k] = (OUT_W-1)'(MAG);
    end

    logic             neg_q;
    logic [IDX_W-1:0] idx_q;
    logic [OUT_W-1:0] mag_ext;

    // stage 1: quadrant fold
    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q <= 1'b0;
            idx_q <= '0;
        end else begin
            neg_q <= addr_i[ADDR_W-1];
            idx_q <= addr_i[ADDR_W-2] ? ~addr_i[IDX_W-1:0] : addr_i[IDX_W-1:0];
        end
    end

    assign mag_ext = {1'b0, rom[idx_q]};

    // stage 2: lookup and sign
    always_ff @(posedge clk) begin
        if (rst) sample_o <= '0;
        else     sample_o <= neg_q ? -$signed(mag_ext) : $signed(mag_ext);
    end

    // R6
    no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
        sample_o != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

// File: rtl/nco_serial_synth.sv
module nco_serial_synth #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_frame,
    input  logic                    ser_clk,
    input  logic                    ser_dat,
    input  logic                    upd,
    output logic signed [OUT_W-1:0] sample_o
);
    logic [ACC_W-1:0] stage_w, commit_word, live_q, phase;
    logic             commit;

    nco_serial_loader #(.WORD_W(ACC_W)) loader_i (
        .clk          (clk),
        .rst          (rst),
        .ser_frame    (ser_frame),
        .ser_clk      (ser_clk),
        .ser_dat      (ser_dat),
        .stage_o      (stage_w),
        .commit_o     (commit),
        .commit_word_o(commit_word)
    );

    // live tuning word; a same-cycle commit is forwarded (R4)
    always_ff @(posedge clk) begin
        if (rst)      live_q <= '0;
        else if (upd) live_q <= commit ? commit_word : stage_w;
    end

    nco_phase_acc #(.ACC_W(ACC_W)) acc_i (
        .clk    (clk),
        .rst    (rst),
        .step_i (live_q),
        .phase_o(phase)
    );

    nco_sine_lut #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) lut_i (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (phase[ACC_W-1 -: ADDR_W]),
        .sample_o(sample_o)
    );

    // R3
    live_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(live_q));
endmodule

// File: tb/nco_serial_synth_tb.sv
module nco_serial_synth_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_frame = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, upd = 1'b0;
    logic signed [15:0] sample_o;

    int n_chk = 0, n_bad = 0;

    // reference model state, built from the requirements
    logic [31:0] m_stage = '0, m_live = '0, m_ph = '0, m_s1 = '0, m_s2 = '0;

    typedef struct packed { logic [31:0] word; logic [15:0] run; } vec_t;
    localparam vec_t VEC [6] = '{
        '{32'h0BF258BF, 16'd40}, '{32'h40000000, 16'd12}, '{32'h80000000, 16'd12},
        '{32'hFFFFFFFF, 16'd20}, '{32'h12345678, 16'd30}, '{32'h00C00001, 16'd30}
    };

    always #4 clk = ~clk;

    nco_serial_synth dut_i (
        .clk(clk), .rst(rst), .ser_frame(ser_frame), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .upd(upd), .sample_o(sample_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= '0; m_live <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            m_ph <= m_ph + m_live;
            if (upd) m_live <= m_stage;
            m_s1 <= m_ph;
            m_s2 <= m_s1;
        end
    end

    function automatic int ref_sine(input logic [31:0] ph);
        logic [1:0] q;
        logic [7:0] i, j;
        int v;
        q = ph[31:30];
        i = ph[29:22];
        j = q[0] ? ~i : i;
        v = $rtoi(32767.0 * $sin(6.283185307179586 * (real'(j) + 0.5) / 1024.0) + 0.5);
        return q[1] ? -v : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_run(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(req, int'(sample_o), ref_sine(m_s2));
        end
    endtask

    task automatic send(input logic [31:0] w, input int nbits, input bit with_upd);
        @(negedge clk) ser_frame = 1'b1;
        repeat (2) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            ser_dat = (b < 32) ? w[31-b] : 1'b0;
            ser_clk = 1'b0;
            @(negedge clk) ser_clk = 1'b1;
            @(negedge clk) ser_clk = 1'b0;
        end
        @(negedge clk);
        ser_frame = 1'b0;
        if (nbits == 32) m_stage = w;
        if (with_upd) upd = 1'b1;
        @(negedge clk) upd = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk) upd = 1'b1;
        @(negedge clk) upd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int held;
        repeat (3) @(negedge clk);
        check("R9 reset output", int'(sample_o), 0);
        rst = 1'b0;
        check_run("R8 zero word after reset", 6);

        // table of tuning words: load, update, compare against reference
        for (int r = 0; r < 6; r++) begin
            send(VEC[r].word, 32, 1'b0);
            pulse_upd();
            check_run("R1 R5 R6 R7 table", int'(VEC[r].run));
        end

        // R2: short and long frames are dropped
        send(32'h01000000, 31, 1'b0);
        pulse_upd();
        check_run("R2 short frame", 20);
        send(32'h02000000, 33, 1'b0);
        pulse_upd();
        check_run("R2 long frame", 20);

        // R10: bit clock toggles with the frame low
        for (int b = 0; b < 40; b++) begin
            @(negedge clk) begin ser_dat = 1'b1; ser_clk = ~ser_clk; end
        end
        @(negedge clk) ser_clk = 1'b0;
        pulse_upd();
        check_run("R10 clock outside frame", 16);

        // R3: committed frame without strobe leaves frequency alone
        send(32'h03000000, 32, 1'b0);
        check_run("R3 no strobe", 16);
        pulse_upd();
        check_run("R3 strobe applies", 16);

        // R4: close of frame and strobe in the same cycle
        send(32'h05555555, 32, 1'b1);
        check_run("R4 same-cycle commit", 24);

        // R8: zero word freezes output
        send(32'h00000000, 32, 1'b1);
        repeat (3) @(negedge clk);
        held = int'(sample_o);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R8 constant output", int'(sample_o), held);
        end

        // R9: reset in mid-run
        send(32'h0BF258BF, 32, 1'b1);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        m_stage = '0;
        repeat (2) @(negedge clk);
        check("R9 reset mid-run", int'(sample_o), 0);
        rst = 1'b0;
        pulse_upd();
        check_run("R9 cleared words", 8);
        check("R9 phase zero value", int'(sample_o), ref_sine(32'h0));

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule